// File: doc/BRIEF.md
# SMI Cause Status Register

This block collects the causes of a system-management interrupt into one 16-bit status word and drives an active-low SMI line from it. Host logic pulses event inputs: hub SMI message, hub SCI message, watchdog expiry, data-out register write and data-in register write. Each pulse sets a sticky bit that software reads through the register port. Software clears a bit by writing 1 to its position. A separate level input for redirected NMI events is mirrored straight into bit 0, which software cannot clear.

The block also monitors BIOS writes. A status bit sets when the write-protect control rises while the lock-down control is set. It also sets when a write reaches BIOS space while write-protect is set. Writes aimed at the lower alias of BIOS space are excluded.

A century bit lives in a slower RTC clock domain. It is set by a BCD year rollover from 99 to 00 and is cleared by a toggle handshake that crosses the domains. The host read returns the synchronised RTC-domain value, so a clear only appears once the RTC side has performed it.

Top module: `smi_cause_reg`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `smi_n` is 1.
- R2: A one-cycle pulse sets its status bit, which reads 1 after the next `clk` edge. The pulses map as follows: hub SMI to bit 10, hub SCI to bit 9, watchdog to bit 3, data-out write to bit 2 and data-in write to bit 1.
- R3: Status bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. Bits 15:11 and 6:4 always read 0.
- R4: A rise of `wp_ctrl` while `lock_ctrl` is 1 sets bit 8. A rise while `lock_ctrl` is 0 does not.
- R5: A `bios_wr` pulse while `wp_ctrl` is 1 sets bit 8. With `wp_ctrl` at 0 it does not.
- R6: A `bios_wr` pulse with `bios_wr_low_alias` at 1 never sets bit 8.
- R7: Bit 7 sets when `year_val`, sampled on `rtc_clk`, goes from 8'h99 to 8'h00. No other consecutive BCD year step sets it.
- R8: Writing 1 to bit 7 clears it only after the RTC-domain handshake completes, so reads stay 1 until then. A second clear write while a request is pending is ignored.
- R9: Driving `rtc_rst_n` low clears bit 7.
- R10: Bit 0 mirrors `nmi_redir_sts` with no delay, and a write of 1 does not clear it.
- R11: `smi_n` is 0 exactly when `smi_en` is 1 and any status bit reads 1.
- R12: When an event pulse and a clear write hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Host active-low asynchronous reset |
| rtc_clk | input | 1 | Slow RTC clock |
| rtc_rst_n | input | 1 | RTC-domain active-low reset; also clears bit 7 |
| reg_wr | input | 1 | Register write strobe (write-1-to-clear) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Status read value |
| smi_en | input | 1 | Global SMI enable |
| hub_smi_msg | input | 1 | Hub SMI message pulse |
| hub_sci_msg | input | 1 | Hub SCI message pulse |
| wdog_expire | input | 1 | Watchdog reached zero pulse |
| dout_wr | input | 1 | Data-out register write pulse |
| din_wr | input | 1 | Data-in register write pulse |
| nmi_redir_sts | input | 1 | Redirected-NMI status level |
| wp_ctrl | input | 1 | BIOS write-protect control level |
| lock_ctrl | input | 1 | BIOS lock-down control level |
| bios_wr | input | 1 | Write to BIOS space pulse |
| bios_wr_low_alias | input | 1 | Current BIOS write targets the lower alias |
| year_val | input | 8 | BCD year byte, RTC domain |
| smi_n | output | 1 | Active-low SMI request |

## Verification
A wrong status flop in the host domain appears on `reg_rdata` and `smi_n` one `clk` edge after the event or write. The bench therefore samples each bit one cycle after every stimulus, across all event positions and all BIOS control combinations. A fault in the century path or in the clear handshake only shows after the synchroniser delay, a few `rtc_clk` periods. It shows either as a bit that never clears or as a rollover that is missed or dropped. The bench waits a bounded number of RTC periods before sampling, and it holds the bit across a long window to catch a stray second clear.

// File: rtl/smi_cause_reg.sv
module smi_cause_reg #(
  parameter int DW = 16,
  parameter int YW = 8,
  parameter logic [YW-1:0] YEAR_LAST  = 8'h99,
  parameter logic [YW-1:0] YEAR_FIRST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtc_clk,
  input  logic          rtc_rst_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          smi_en,
  input  logic          hub_smi_msg,
  input  logic          hub_sci_msg,
  input  logic          wdog_expire,
  input  logic          dout_wr,
  input  logic          din_wr,
  input  logic          nmi_redir_sts,
  input  logic          wp_ctrl,
  input  logic          lock_ctrl,
  input  logic          bios_wr,
  input  logic          bios_wr_low_alias,
  input  logic [YW-1:0] year_val,
  output logic          smi_n
);
  localparam int B_HSMI = 10, B_HSCI = 9, B_BIOS = 8, B_CENT = 7;
  localparam int B_WDOG = 3, B_DOUT = 2, B_DIN = 1, B_NMI = 0;
  localparam logic [DW-1:0] HOST_MASK = DW'((1 << B_HSMI) | (1 << B_HSCI) | (1 << B_BIOS) |
                                            (1 << B_WDOG) | (1 << B_DOUT) | (1 << B_DIN));

  logic [DW-1:0] host_q, clr, set;
  logic          wp_q, bios_viol;

  assign clr = reg_wr ? reg_wdata : '0;
  assign bios_viol = (wp_ctrl & ~wp_q & lock_ctrl) | (bios_wr & wp_ctrl & ~bios_wr_low_alias);

  always_comb begin
    set = '0;
    set[B_HSMI] = hub_smi_msg;
    set[B_HSCI] = hub_sci_msg;
    set[B_BIOS] = bios_viol;
    set[B_WDOG] = wdog_expire;
    set[B_DOUT] = dout_wr;
    set[B_DIN]  = din_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q <= '0;
      wp_q   <= 1'b0;
    end else begin
      host_q <= ((host_q & ~clr) | set) & HOST_MASK;
      wp_q   <= wp_ctrl;
    end
  end

  // century bit, RTC domain, cleared through a toggle handshake
  logic          req_tog, ack_s1, ack_s2, cent_s1, cent_s2, pend;
  logic          rq_s1, rq_s2, rq_seen, cent_q;
  logic [YW-1:0] year_q;

  assign pend = req_tog ^ ack_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog <= 1'b0;
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
      cent_s1 <= 1'b0;
      cent_s2 <= 1'b0;
    end else begin
      if (clr[B_CENT] && !pend) req_tog <= ~req_tog;
      ack_s1  <= rq_seen;
      ack_s2  <= ack_s1;
      cent_s1 <= cent_q;
      cent_s2 <= cent_s1;
    end
  end

  always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      rq_s1   <= 1'b0;
      rq_s2   <= 1'b0;
      rq_seen <= 1'b0;
      cent_q  <= 1'b0;
      year_q  <= '0;
    end else begin
      rq_s1   <= req_tog;
      rq_s2   <= rq_s1;
      rq_seen <= rq_s2;
      year_q  <= year_val;
      cent_q  <= (year_q == YEAR_LAST && year_val == YEAR_FIRST) | (cent_q & ~(rq_s2 ^ rq_seen));
    end
  end

  always_comb begin
    reg_rdata = host_q;
    reg_rdata[B_CENT] = cent_s2;
    reg_rdata[B_NMI]  = nmi_redir_sts;
  end

  assign smi_n = ~(smi_en & |reg_rdata);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (host_q[B_HSMI] && !(reg_wr && reg_wdata[B_HSMI])) |=> host_q[B_HSMI]);
  a_r4_wp_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wp_ctrl) && lock_ctrl) |=> host_q[B_BIOS]);
  a_r6_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bios_wr && bios_wr_low_alias && !lock_ctrl && !host_q[B_BIOS]) |=> !host_q[B_BIOS]);
  a_r8_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[B_CENT] && pend) |=> $stable(req_tog));
  a_r11_smi_low: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_en && host_q != '0) |-> !smi_n);
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_sci_msg && reg_wr && reg_wdata[B_HSCI]) |=> host_q[B_HSCI]);
endmodule

// File: tb/smi_cause_reg_test.sv
module smi_cause_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int RTC_PERIOD = 34;

  logic clk = 0, rst_n = 0, rtc_clk = 0, rtc_rst_n = 0;
  logic reg_wr = 0, smi_en = 0, nmi = 0, wp = 0, lock = 0, bwr = 0, alias_wr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [4:0] ev = 0;
  logic [7:0] year = 0;
  logic smi_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(RTC_PERIOD/2) rtc_clk = ~rtc_clk;

  smi_cause_reg uut (
    .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
    .reg_wr(reg_wr), .reg_wdata(wdata), .reg_rdata(rdata), .smi_en(smi_en),
    .hub_smi_msg(ev[0]), .hub_sci_msg(ev[1]), .wdog_expire(ev[2]),
    .dout_wr(ev[3]), .din_wr(ev[4]), .nmi_redir_sts(nmi),
    .wp_ctrl(wp), .lock_ctrl(lock), .bios_wr(bwr), .bios_wr_low_alias(alias_wr),
    .year_val(year), .smi_n(smi_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr = 1; wdata = d; hcyc(1); reg_wr = 0; wdata = 0;
  endtask

  task automatic rtc_wait(input int n);
    repeat (n) @(negedge rtc_clk);
    hcyc(3);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int pos[5] = '{10, 9, 3, 2, 1};
    hcyc(3);
    rst_n = 1; rtc_rst_n = 1;
    hcyc(1);
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 smi_n", {15'b0, smi_n}, 16'h1);
    smi_en = 1;

    for (int i = 0; i < 5; i++) begin
      ev[i] = 1; hcyc(1); ev = 0;
      chk("R2 event bit", rdata, 16'(1 << pos[i]));
      chk("R11 smi low", {15'b0, smi_n}, 16'h0);
      wr(16'h0);
      chk("R3 write 0 keeps", rdata, 16'(1 << pos[i]));
      wr(16'(1 << pos[i]));
      chk("R3 write 1 clears", rdata, 16'h0);
      chk("R11 smi high", {15'b0, smi_n}, 16'h1);
    end

    ev = 5'h1F; hcyc(1); ev = 0;
    chk("R3 reserved zero", rdata, 16'h060E);
    smi_en = 0; hcyc(1);
    chk("R11 disabled", {15'b0, smi_n}, 16'h1);
    smi_en = 1;
    wr(16'h070E);
    chk("R3 clear all", rdata, 16'h0);

    ev[1] = 1; reg_wr = 1; wdata = 16'h0200; hcyc(1); ev = 0; reg_wr = 0; wdata = 0;
    chk("R12 set wins", rdata, 16'h0200);
    wr(16'h0200);

    for (int k = 0; k < 8; k++) begin
      logic wv, lk, al;
      wv = k[0]; lk = k[1]; al = k[2];
      wp = 0; lock = lk; hcyc(2);
      wr(16'h0100);
      wp = wv; hcyc(1);
      chk("R4 wp rise", rdata, {7'b0, wv & lk, 8'b0});
      wr(16'h0100);
      alias_wr = al; bwr = 1; hcyc(1); bwr = 0; alias_wr = 0;
      if (al) chk("R6 alias ignored", rdata, 16'h0);
      else    chk("R5 protected write", rdata, {7'b0, wv, 8'b0});
      wr(16'h0100);
    end
    wp = 0; lock = 0; hcyc(1);

    nmi = 1; #1;
    chk("R10 mirror", rdata, 16'h0001);
    chk("R11 nmi smi", {15'b0, smi_n}, 16'h0);
    hcyc(1); wr(16'h0001);
    chk("R10 not cleared", rdata, 16'h0001);
    nmi = 0; #1;
    chk("R10 follows input", rdata, 16'h0);
    hcyc(1);

    for (int y = 1; y < 100; y++) begin
      @(negedge rtc_clk); year = 8'(((y / 10) << 4) | (y % 10));
      rtc_wait(1);
      chk("R7 no rollover", rdata, 16'h0);
    end
    @(negedge rtc_clk); year = 8'h00;
    rtc_wait(2);
    chk("R7 rollover", rdata, 16'h0080);
    chk("R11 century smi", {15'b0, smi_n}, 16'h0);

    wr(16'h0080);
    chk("R8 still set", rdata, 16'h0080);
    rtc_wait(6);
    chk("R8 cleared", rdata, 16'h0);

    @(negedge rtc_clk); year = 8'h99;
    @(negedge rtc_clk); year = 8'h00;
    rtc_wait(2);
    chk("R7 second rollover", rdata, 16'h0080);
    wr(16'h0080); wr(16'h0080);
    rtc_wait(8);
    chk("R8 cleared once", rdata, 16'h0);
    @(negedge rtc_clk); year = 8'h99;
    @(negedge rtc_clk); year = 8'h00;
    rtc_wait(2);
    chk("R8 set after clear", rdata, 16'h0080);
    rtc_wait(12);
    chk("R8 no stray clear", rdata, 16'h0080);

    @(negedge rtc_clk); rtc_rst_n = 0;
    @(negedge rtc_clk); rtc_rst_n = 1;
    rtc_wait(4);
    chk("R9 rtc reset", rdata, 16'h0);
    chk("R9 smi released", {15'b0, smi_n}, 16'h1);

    finish_run();
  end
endmodule